// File: doc/BRIEF.md
# Partitioned Pixel Arithmetic Unit

This block performs packed integer operations on a 64-bit word. The word is split into 16-bit or 32-bit lanes for addition, subtraction and comparison. Two byte-placement operations rearrange data for pixel processing:

- Merge interleaves the low bytes of both operands.
- Expand widens four bytes into 16-bit fixed-point lanes.

A narrow mode restricts addition and subtraction to the low 32 bits of the word. A compare returns one flag bit per lane, packed at the bottom of the result.

The datapath is combinational. With the default setting its result and an illegal-operation flag are captured in an output register, so a result appears one clock edge after its operands. A pipeline stage feeds the opcode, the lane select and both operands every cycle. No handshake is involved.

Top module: `pix_simd_alu`

## Requirements
- R1: While `rst` is high at a rising clock edge, the result becomes zero and the illegal flag becomes 0 after that edge.
- R2: With `OUT_REG` = 1, the result and the flag for the inputs present at a rising edge appear after that edge, and stay unchanged until the next edge.
- R3: Opcode 0 adds `opb_i` and `opa_i` lane by lane. Lane select 0 gives four 16-bit lanes and lane select 1 gives two 32-bit lanes. Each lane wraps modulo its width, with no carry into the next lane.
- R4: Opcode 1 computes `opb_i` lane minus `opa_i` lane, with the same lane layout as R3 and wrapping modulo the lane width.
- R5: Opcodes 2 (add) and 3 (subtract) work only on the low 32 bits, as two 16-bit lanes (lane select 0) or one 32-bit lane (lane select 1). Result bits 63..32 are zero.
- R6: Opcodes 4, 5, 6 and 7 test, for each lane, whether `opa_i` is greater than, equal to, less than or equal to, or not equal to `opb_i`. Both lanes are treated as unsigned, with the lane layout of R3.
- R7: The compare outcome of lane i (lane 0 is the least significant) goes to result bit i. This uses bits 3..0 for 16-bit lanes and bits 1..0 for 32-bit lanes. Every other result bit is zero.
- R8: Opcode 8 interleaves bytes. For k = 0..3, result byte 2k+1 is byte k of `opa_i` and result byte 2k is byte k of `opb_i`.
- R9: Opcode 9 takes byte k (k = 0..3) of `opa_i`, zero-extends it and shifts it left by 4 into 16-bit result lane k. `opb_i` and the lane select have no effect.
- R10: Opcodes 10 to 15 give a zero result with the illegal flag set. So do opcodes 0 to 7 with lane select 2 or 3. Every legal operation leaves the flag at 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| op_i | input | 4 | Operation code |
| lane_i | input | 2 | Lane size select: 0 = 16-bit, 1 = 32-bit |
| opa_i | input | 64 | First operand |
| opb_i | input | 64 | Second operand |
| res_o | output | 64 | Result |
| illegal_o | output | 1 | Unsupported opcode or lane size |

## Verification
The bench sweeps every opcode and lane select over operand pairs that contain all-ones lanes, sign-bit lanes and equal lanes:

- The all-ones and sign-bit lanes catch a carry or borrow that leaks across a lane boundary.
- The sign-bit lanes catch a compare done as signed, which flips greater-than whenever the top lane bit differs.
- The equal lanes catch a less-or-equal built as less-than.

A swapped subtraction or merge order shows as mirrored values. An expand that shifts by the wrong amount, or reads the wrong operand, fails every nonzero pattern. Narrow add with garbage in the upper half would leave nonzero bits above 31. Unused lane selects are driven on purpose, so a decoder that treats them as 32-bit lanes raises no flag and is caught.

// File: rtl/pix_simd_pkg.sv
package pix_simd_pkg;

  localparam logic [3:0] OP_ADD    = 4'd0;
  localparam logic [3:0] OP_SUB    = 4'd1;
  localparam logic [3:0] OP_ADDN   = 4'd2;
  localparam logic [3:0] OP_SUBN   = 4'd3;
  localparam logic [3:0] OP_CGT    = 4'd4;
  localparam logic [3:0] OP_CEQ    = 4'd5;
  localparam logic [3:0] OP_CLE    = 4'd6;
  localparam logic [3:0] OP_CNE    = 4'd7;
  localparam logic [3:0] OP_MERGE  = 4'd8;
  localparam logic [3:0] OP_EXPAND = 4'd9;

  localparam logic [1:0] LANE_16 = 2'd0;
  localparam logic [1:0] LANE_32 = 2'd1;

endpackage

// File: rtl/pix_lane_addsub.sv
module pix_lane_addsub #(
  parameter int DATA_W = 64,
  parameter int LANE_W = 16
) (
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  output logic [DATA_W-1:0] sum_o,
  output logic [DATA_W-1:0] dif_o
);
  localparam int NLANE = DATA_W / LANE_W;

  for (genvar g = 0; g < NLANE; g++) begin : g_lane
    logic [LANE_W-1:0] la, lb;
    assign la = a_i[g*LANE_W +: LANE_W];
    assign lb = b_i[g*LANE_W +: LANE_W];
    assign sum_o[g*LANE_W +: LANE_W] = lb + la;
    assign dif_o[g*LANE_W +: LANE_W] = lb - la;
  end
endmodule

// File: rtl/pix_lane_cmp.sv
module pix_lane_cmp #(
  parameter int DATA_W = 64,
  parameter int LANE_W = 16,
  parameter int NLANE  = DATA_W / LANE_W
) (
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  output logic [NLANE-1:0]  gt_o,
  output logic [NLANE-1:0]  eq_o
);
  for (genvar g = 0; g < NLANE; g++) begin : g_lane
    logic [LANE_W-1:0] la, lb;
    assign la = a_i[g*LANE_W +: LANE_W];
    assign lb = b_i[g*LANE_W +: LANE_W];
    assign gt_o[g] = la > lb;
    assign eq_o[g] = la == lb;
  end
endmodule

// File: rtl/pix_byte_shuffle.sv
module pix_byte_shuffle #(
  parameter int HALF_W = 32,
  parameter int BYTE_W = 8,
  parameter int EXP_SH = 4
) (
  input  logic [HALF_W-1:0]   a_lo_i,
  input  logic [HALF_W-1:0]   b_lo_i,
  output logic [2*HALF_W-1:0] mrg_o,
  output logic [2*HALF_W-1:0] exp_o
);
  localparam int NBYTE = HALF_W / BYTE_W;
  localparam int WIDE  = 2 * BYTE_W;
  localparam int PAD   = WIDE - BYTE_W - EXP_SH;

  for (genvar k = 0; k < NBYTE; k++) begin : g_byte
    assign mrg_o[k*WIDE +: WIDE] = {a_lo_i[k*BYTE_W +: BYTE_W], b_lo_i[k*BYTE_W +: BYTE_W]};
    assign exp_o[k*WIDE +: WIDE] = {{PAD{1'b0}}, a_lo_i[k*BYTE_W +: BYTE_W], {EXP_SH{1'b0}}};
  end
endmodule

// File: rtl/pix_simd_alu.sv
module pix_simd_alu
  import pix_simd_pkg::*;
#(
  parameter int DATA_W  = 64,
  parameter int OUT_REG = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [3:0]        op_i,
  input  logic [1:0]        lane_i,
  input  logic [DATA_W-1:0] opa_i,
  input  logic [DATA_W-1:0] opb_i,
  output logic [DATA_W-1:0] res_o,
  output logic              illegal_o
);
  localparam int HALF_W = DATA_W / 2;
  localparam int N16    = DATA_W / 16;
  localparam int N32    = DATA_W / 32;

  logic [DATA_W-1:0] sum16, dif16, sum32, dif32, mrg, expd;
  logic [N16-1:0]    gt16, eq16;
  logic [N32-1:0]    gt32, eq32;
  logic [DATA_W-1:0] nxt_res;
  logic              nxt_ill;
  logic              wide, lane_ok;
  logic [DATA_W-1:0] arith;
  logic [N16-1:0]    mask16;
  logic [N32-1:0]    mask32;

  pix_lane_addsub #(.DATA_W(DATA_W), .LANE_W(16)) u_as16 (
    .a_i(opa_i), .b_i(opb_i), .sum_o(sum16), .dif_o(dif16));
  pix_lane_addsub #(.DATA_W(DATA_W), .LANE_W(32)) u_as32 (
    .a_i(opa_i), .b_i(opb_i), .sum_o(sum32), .dif_o(dif32));
  pix_lane_cmp #(.DATA_W(DATA_W), .LANE_W(16)) u_cmp16 (
    .a_i(opa_i), .b_i(opb_i), .gt_o(gt16), .eq_o(eq16));
  pix_lane_cmp #(.DATA_W(DATA_W), .LANE_W(32)) u_cmp32 (
    .a_i(opa_i), .b_i(opb_i), .gt_o(gt32), .eq_o(eq32));
  pix_byte_shuffle #(.HALF_W(HALF_W)) u_shuf (
    .a_lo_i(opa_i[HALF_W-1:0]), .b_lo_i(opb_i[HALF_W-1:0]),
    .mrg_o(mrg), .exp_o(expd));

  assign wide    = (lane_i == LANE_32);
  assign lane_ok = (lane_i == LANE_16) || wide;

  always_comb begin
    arith  = '0;
    mask16 = '0;
    mask32 = '0;
    case (op_i)
      OP_ADD, OP_ADDN: arith = wide ? sum32 : sum16;
      OP_SUB, OP_SUBN: arith = wide ? dif32 : dif16;
      OP_CGT: begin mask16 = gt16;  mask32 = gt32;  end
      OP_CEQ: begin mask16 = eq16;  mask32 = eq32;  end
      OP_CLE: begin mask16 = ~gt16; mask32 = ~gt32; end
      OP_CNE: begin mask16 = ~eq16; mask32 = ~eq32; end
      default: ;
    endcase
  end

  always_comb begin
    nxt_res = '0;
    nxt_ill = 1'b0;
    case (op_i)
      OP_ADD, OP_SUB: begin
        if (lane_ok) nxt_res = arith;
        else nxt_ill = 1'b1;
      end
      OP_ADDN, OP_SUBN: begin
        if (lane_ok) nxt_res = {{HALF_W{1'b0}}, arith[HALF_W-1:0]};
        else nxt_ill = 1'b1;
      end
      OP_CGT, OP_CEQ, OP_CLE, OP_CNE: begin
        if (!lane_ok) nxt_ill = 1'b1;
        else if (wide) nxt_res = {{(DATA_W-N32){1'b0}}, mask32};
        else nxt_res = {{(DATA_W-N16){1'b0}}, mask16};
      end
      OP_MERGE:  nxt_res = mrg;
      OP_EXPAND: nxt_res = expd;
      default:   nxt_ill = 1'b1;
    endcase
  end

  if (OUT_REG != 0) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst) begin
        res_o     <= '0;
        illegal_o <= 1'b0;
      end else begin
        res_o     <= nxt_res;
        illegal_o <= nxt_ill;
      end
    end
  end else begin : g_comb
    logic unused_clk;
    assign unused_clk = clk ^ rst;
    assign res_o      = nxt_res;
    assign illegal_o  = nxt_ill;
  end
endmodule

// File: rtl/pix_simd_alu_chk.sv
module pix_simd_alu_chk
  import pix_simd_pkg::*;
#(
  parameter int DATA_W  = 64,
  parameter int OUT_REG = 1
) (
  input logic              clk,
  input logic              rst,
  input logic [3:0]        op_i,
  input logic [1:0]        lane_i,
  input logic [DATA_W-1:0] opa_i,
  input logic [DATA_W-1:0] opb_i,
  input logic [DATA_W-1:0] res_o,
  input logic              illegal_o
);
  if (OUT_REG != 0) begin : g_chk
    AST_RESET_CLEAR: assert property (@(posedge clk)
      rst |=> (res_o == '0 && !illegal_o)); // R1
    AST_ILLEGAL_ZERO: assert property (@(posedge clk) disable iff (rst)
      illegal_o |-> res_o == '0); // R10
    AST_BAD_LANE_FLAG: assert property (@(posedge clk) disable iff (rst)
      (op_i < OP_MERGE && lane_i > LANE_32) |=> illegal_o); // R10
    AST_CMP_HIGH_ZERO: assert property (@(posedge clk) disable iff (rst)
      (op_i >= OP_CGT && op_i <= OP_CNE) |=> res_o[DATA_W-1:4] == '0); // R7
    AST_NARROW_UPPER: assert property (@(posedge clk) disable iff (rst)
      (op_i == OP_ADDN || op_i == OP_SUBN) |=> res_o[DATA_W-1:DATA_W/2] == '0); // R5
    AST_MERGE_LOW_BYTE: assert property (@(posedge clk) disable iff (rst)
      (op_i == OP_MERGE) |=> res_o[15:0] == {$past(opa_i[7:0]), $past(opb_i[7:0])}); // R8
    AST_EXPAND_LANE0: assert property (@(posedge clk) disable iff (rst)
      (op_i == OP_EXPAND) |=> res_o[15:0] == {4'h0, $past(opa_i[7:0]), 4'h0}); // R9
  end else begin : g_none
    always_comb begin
      AST_ILLEGAL_ZERO_C: assert (!illegal_o || res_o == '0); // R10
    end
    logic unused;
    assign unused = ^{clk, rst, op_i, lane_i, opa_i, opb_i};
  end
endmodule

bind pix_simd_alu pix_simd_alu_chk #(.DATA_W(DATA_W), .OUT_REG(OUT_REG)) u_chk (
  .clk(clk), .rst(rst), .op_i(op_i), .lane_i(lane_i), .opa_i(opa_i),
  .opb_i(opb_i), .res_o(res_o), .illegal_o(illegal_o));

// File: tb/test_pix_simd_alu.sv
module test_pix_simd_alu;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  op_i = '0;
  logic [1:0]  lane_i = '0;
  logic [63:0] opa_i = '0;
  logic [63:0] opb_i = '0;
  logic [63:0] res_o;
  logic        illegal_o;
  int n_chk = 0;
  int n_err = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  pix_simd_alu #(.DATA_W(64), .OUT_REG(1)) i_pix_simd_alu (
    .clk(clk), .rst(rst), .op_i(op_i), .lane_i(lane_i),
    .opa_i(opa_i), .opb_i(opb_i), .res_o(res_o), .illegal_o(illegal_o));

  function automatic logic [63:0] pat(int k);
    case (k)
      0: return 64'h0;
      1: return 64'hFFFF_FFFF_FFFF_FFFF;
      2: return 64'h8000_8000_8000_8000;
      3: return 64'h7FFF_FFFF_0001_8001;
      4: return 64'h0123_4567_89AB_CDEF;
      5: return 64'hFEDC_BA98_7654_3210;
      6: return 64'h0001_0001_0001_0001;
      default: return 64'h8000_0000_FFFF_0001;
    endcase
  endfunction

  function automatic logic [64:0] model(int op, int lane, logic [63:0] a, logic [63:0] b);
    longint unsigned r = 0;
    longint unsigned msk, x, y, v;
    int lw, n;
    lw = (lane == 0) ? 16 : 32;
    n = 64 / lw;
    msk = (64'd1 << lw) - 1;
    if (op <= 7 && lane > 1) return {1'b1, 64'h0};
    if (op <= 3) begin
      for (int i = 0; i < n; i++) begin
        x = (a >> (i * lw)) & msk;
        y = (b >> (i * lw)) & msk;
        v = ((op % 2) == 1) ? (y - x) : (y + x);
        r = r | ((v & msk) << (i * lw));
      end
      if (op >= 2) r = r & 64'hFFFF_FFFF;
      return {1'b0, r};
    end
    if (op <= 7) begin
      for (int i = 0; i < n; i++) begin
        bit c;
        x = (a >> (i * lw)) & msk;
        y = (b >> (i * lw)) & msk;
        case (op)
          4: c = x > y;
          5: c = x == y;
          6: c = x <= y;
          default: c = x != y;
        endcase
        if (c) r = r | (64'd1 << i);
      end
      return {1'b0, r};
    end
    if (op == 8) begin
      for (int i = 0; i < 4; i++) begin
        r = r | (((a >> (8 * i)) & 64'hFF) << (16 * i + 8));
        r = r | (((b >> (8 * i)) & 64'hFF) << (16 * i));
      end
      return {1'b0, r};
    end
    if (op == 9) begin
      for (int i = 0; i < 4; i++)
        r = r | ((((a >> (8 * i)) & 64'hFF) * 16) << (16 * i));
      return {1'b0, r};
    end
    return {1'b1, 64'h0};
  endfunction

  function automatic string tag(int op, int lane);
    if (op > 9 || (op <= 7 && lane > 1)) return "R10";
    case (op)
      0: return "R3";
      1: return "R4";
      2, 3: return "R5";
      8: return "R8";
      9: return "R9";
      default: return "R6";
    endcase
  endfunction

  task automatic check(string req, logic [63:0] got, logic [63:0] exp_v, bit gi, bit ei);
    n_chk++;
    if (got !== exp_v || gi !== ei) begin
      n_err++;
      $display("FAIL %s: got res=%h ill=%b expected res=%h ill=%b", req, got, gi, exp_v, ei);
    end
  endtask

  task automatic run(int op, int lane, logic [63:0] a, logic [63:0] b, string req);
    logic [64:0] e;
    @(negedge clk);
    op_i = 4'(op); lane_i = 2'(lane); opa_i = a; opb_i = b;
    e = model(op, lane, a, b);
    @(negedge clk);
    check(req, res_o, e[63:0], illegal_o, e[64]);
  endtask

  initial begin : wdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin : main
    logic [63:0] held;
    op_i = 4'd0; opa_i = 64'hFFFF; opb_i = 64'h1;
    repeat (3) @(negedge clk);
    check("R1", res_o, 64'h0, illegal_o, 1'b0);
    rst = 1'b0;
    // R3 wrap within lanes, no carry into neighbours
    run(0, 0, 64'h0001_0001_0001_0001, 64'hFFFF_FFFF_FFFF_FFFF, "R3");
    check("R3", res_o, 64'h0, illegal_o, 1'b0);
    run(0, 1, 64'h0000_0001_0000_0001, 64'h0000_FFFF_FFFF_FFFF, "R3");
    check("R3", res_o, 64'h0001_0000_0000_0000, illegal_o, 1'b0);
    // R4 B minus A
    run(1, 0, 64'h0001_0000_0003_0001, 64'h0000_0000_0005_0003, "R4");
    check("R4", res_o, 64'hFFFF_0000_0002_0002, illegal_o, 1'b0);
    // R5 narrow add ignores upper half
    run(2, 0, 64'hAAAA_AAAA_0001_0002, 64'h5555_5555_0003_FFFF, "R5");
    check("R5", res_o, 64'h0000_0000_0004_0001, illegal_o, 1'b0);
    // R7 mask placement for 32-bit lanes: lane1 gt, lane0 not
    run(4, 1, 64'h0000_0002_0000_0001, 64'h0000_0001_0000_0001, "R7");
    check("R7", res_o, 64'h2, illegal_o, 1'b0);
    // R6 unsigned: 0x8000 > 0x7FFF in lane 0 only
    run(4, 0, 64'h0000_0000_0000_8000, 64'h0000_0000_0000_7FFF, "R6");
    check("R6", res_o, 64'h1, illegal_o, 1'b0);
    // R8 merge order
    run(8, 0, 64'hFFFF_FFFF_A3A2_A1A0, 64'hEEEE_EEEE_B3B2_B1B0, "R8");
    check("R8", res_o, 64'hA3B3_A2B2_A1B1_A0B0, illegal_o, 1'b0);
    // R9 expand, lane select and opb ignored
    run(9, 3, 64'h1234_5678_FF80_0102, 64'hDEAD_BEEF_DEAD_BEEF, "R9");
    check("R9", res_o, 64'h0FF0_0800_0010_0020, illegal_o, 1'b0);
    // R10 illegal opcode, then R2 hold until next edge
    run(12, 0, 64'h1, 64'h2, "R10");
    check("R10", res_o, 64'h0, illegal_o, 1'b1);
    run(0, 0, 64'h1, 64'h2, "R2");
    held = res_o;
    @(negedge clk);
    op_i = 4'd0; opa_i = 64'h5; opb_i = 64'h5;
    #2;
    check("R2", res_o, held, illegal_o, 1'b0);
    @(negedge clk);
    check("R2", res_o, 64'hA, illegal_o, 1'b0);
    // sweep all opcodes, lane selects and operand pairs
    for (int op = 0; op < 16; op++)
      for (int ln = 0; ln < 4; ln++)
        for (int i = 0; i < 8; i++)
          for (int j = 0; j < 8; j++)
            run(op, ln, pat(i), pat(j), tag(op, ln));
    // R1 reset clears a raised flag
    run(15, 0, 64'h3, 64'h3, "R10");
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    check("R1", res_o, 64'h0, illegal_o, 1'b0);
    rst = 1'b0;
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule